// File: doc/BRIEF.md
# Return-Stack and Interrupt Sequencer

This unit steers program flow for a small 8-bit processor core. It keeps the program counter and a private return-address stack held in flip-flops. It also holds the interrupt pending, mask and enable state. On each execution step it receives one decoded flow request and the current carry and zero flags. The request is one of: advance, jump, conditional jump, call, conditional call, return or interrupt return. From these it forms the next program counter. Fetch, ALU and register file sit outside and connect only through the ports.

Before any request is honoured, the unit checks for an interrupt. If the enable bit is set and a pending bit meets a set mask bit, the step becomes an interrupt entry. The request of that step is discarded. The current address is pushed, so the discarded instruction runs again after the handler. Carry and zero are copied into shadow bits, the enable bit is cleared, and execution moves to the vector at address 0. An interrupt return undoes all of this in one step. It pops the address, presents the shadow flags with a one-cycle restore pulse and sets the enable bit again. Stack misuse raises a sticky error flag.

Top module: `flow_sequencer`

## Requirements
- R1: After reset the program counter is 1, the error flag, entry pulse and restore pulse are 0, and pending, mask and enable all read as 0.
- R2: A step with op 0 (advance) or op 7 adds one to the program counter. A cycle with step low leaves it unchanged.
- R3: Op 1 loads the target address. Op 2 loads it only when the condition holds and otherwise advances by one. The condition is the zero flag (cond_sel 0) or the carry flag (cond_sel 1), inverted when cond_neg is 1.
- R4: Op 3 (call) pushes the program counter plus one and loads the target. Op 5 (return) loads the most recently pushed address, in last-in first-out order.
- R5: Op 4 (conditional call) behaves as op 3 when the condition of R3 holds. Otherwise it advances by one and pushes nothing.
- R6: A step with enable set and (pending AND mask) nonzero becomes an interrupt entry. It pushes the current program counter, loads 0, captures carry and zero into the shadow bits, clears enable and drives the entry pulse high in the following cycle. The op of that step is ignored.
- R7: Op 6 (interrupt return) pops the program counter, sets enable to 1 and drives the restore pulse high in the following cycle, with the shadow bits still presenting the flags captured at entry.
- R8: Control select 0 reads pending, 1 reads mask, 2 reads enable in bit 0, and 3 reads 0. A write to select 2 sets enable to 1 for any nonzero value and to 0 for zero. A write to select 1 replaces the mask.
- R9: Each cycle the pending register takes the OR of its previous value, or of the written value when select 0 is written, with the external request lines. Pending bits blocked by the mask never cause an entry.
- R10: A call or entry while the stack holds DEPTH entries sets the error flag. The stack is left unchanged, and a refused call advances by one. The error flag stays set until reset.
- R11: A return or interrupt return on an empty stack sets the error flag and advances the program counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One instruction is executed this cycle |
| op_i | input | 3 | Flow request code (0 advance, 1 jump, 2 jump if, 3 call, 4 call if, 5 return, 6 interrupt return, 7 advance) |
| target_i | input | PC_W | Resolved jump or call target |
| cond_sel_i | input | 1 | Condition flag: 0 zero, 1 carry |
| cond_neg_i | input | 1 | Invert the condition |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| irq_req_i | input | IRQ_W | Level interrupt request lines |
| csr_we_i | input | 1 | Control register write strobe |
| csr_sel_i | input | 2 | Control register select |
| csr_wdata_i | input | IRQ_W | Control register write data |
| pc_o | output | PC_W | Program counter |
| irq_entry_o | output | 1 | Pulse: an interrupt entry was made |
| restore_o | output | 1 | Pulse: load flags from the shadow bits |
| carry_sh_o | output | 1 | Shadow carry |
| zero_sh_o | output | 1 | Shadow zero |
| csr_rdata_o | output | IRQ_W | Control register read data |
| stack_err_o | output | 1 | Sticky overflow or underflow flag |

## Verification
The properties assume that reset is applied before the first step. They also assume that csr_sel_i stays on a single value through a cycle in which it is sampled. They take the op code at face value, so any 3-bit value is legal and code 7 must act as an advance. The stimulus changes every input only at the falling clock edge. It changes select only in cycles that carry a write or a read check. Reset is raised again only between phases, so the sticky error flag is seen both rising and holding.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;

    // Flow request codes carried on op_i
    typedef enum logic [2:0] {
        OP_SEQ     = 3'd0,
        OP_JUMP    = 3'd1,
        OP_JUMP_IF = 3'd2,
        OP_CALL    = 3'd3,
        OP_CALL_IF = 3'd4,
        OP_RET     = 3'd5,
        OP_IRET    = 3'd6,
        OP_RSVD    = 3'd7
    } flow_op_e;

    // Control register selects
    typedef enum logic [1:0] {
        CSR_PEND = 2'd0,
        CSR_MASK = 2'd1,
        CSR_ENAB = 2'd2,
        CSR_NONE = 2'd3
    } csr_sel_e;

    // Decoded request, already qualified by its condition
    typedef struct packed {
        logic jump;
        logic call;
        logic ret;
        logic iret;
    } flow_dec_t;

endpackage

// File: rtl/flow_op_decode.sv
module flow_op_decode
    import flow_seq_pkg::*;
(
    input  flow_op_e  op_i,
    input  logic      cond_sel_i,
    input  logic      cond_neg_i,
    input  logic      carry_i,
    input  logic      zero_i,
    output flow_dec_t dec_o
);

    logic cond_hit;

    always_comb begin
        cond_hit = (cond_sel_i ? carry_i : zero_i) ^ cond_neg_i;
        dec_o    = '0;
        case (op_i)
            OP_JUMP:    dec_o.jump = 1'b1;
            OP_JUMP_IF: dec_o.jump = cond_hit;
            OP_CALL:    dec_o.call = 1'b1;
            OP_CALL_IF: dec_o.call = cond_hit;
            OP_RET:     dec_o.ret  = 1'b1;
            OP_IRET:    dec_o.iret = 1'b1;
            default:    dec_o      = '0;
        endcase
    end

endmodule

// File: rtl/flow_ret_stack.sv
module flow_ret_stack #(
    parameter int DEPTH = 16,   // entries, 1 to 32
    parameter int W     = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] top_o,
    output logic         full_o,
    output logic         empty_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
    } stk_t;

    stk_t          st_d, st_q;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;

    always_comb begin
        full_o  = (st_q.cnt == CW'(DEPTH));
        empty_o = (st_q.cnt == '0);
        wr_idx  = IW'(st_q.cnt);
        rd_idx  = IW'(st_q.cnt - CW'(1));
        top_o   = st_q.mem[rd_idx];

        st_d = st_q;
        // requests that would overflow or underflow leave the state alone
        if (push_i && !full_o) begin
            st_d.mem[wr_idx] = push_data_i;
            st_d.cnt         = st_q.cnt + CW'(1);
        end else if (pop_i && !empty_o) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/flow_irq_ctrl.sv
module flow_irq_ctrl
    import flow_seq_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IRQ_W-1:0] irq_req_i,
    input  logic             csr_we_i,
    input  csr_sel_e         csr_sel_i,
    input  logic [IRQ_W-1:0] csr_wdata_i,
    input  logic             enter_i,
    input  logic             leave_i,
    output logic             fire_o,
    output logic [IRQ_W-1:0] csr_rdata_o
);

    typedef struct packed {
        logic [IRQ_W-1:0] pend;
        logic [IRQ_W-1:0] mask;
        logic             enab;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // pending: software value or held value, plus live request levels
        if (csr_we_i && csr_sel_i == CSR_PEND) begin
            st_d.pend = csr_wdata_i | irq_req_i;
        end else begin
            st_d.pend = st_q.pend | irq_req_i;
        end

        if (csr_we_i && csr_sel_i == CSR_MASK) begin
            st_d.mask = csr_wdata_i;
        end

        if (csr_we_i && csr_sel_i == CSR_ENAB) begin
            st_d.enab = |csr_wdata_i;
        end
        if (enter_i) begin
            st_d.enab = 1'b0;
        end else if (leave_i) begin
            st_d.enab = 1'b1;
        end

        fire_o = st_q.enab && |(st_q.pend & st_q.mask);

        case (csr_sel_i)
            CSR_PEND: csr_rdata_o = st_q.pend;
            CSR_MASK: csr_rdata_o = st_q.mask;
            CSR_ENAB: csr_rdata_o = {{(IRQ_W-1){1'b0}}, st_q.enab};
            default:  csr_rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
    import flow_seq_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int DEPTH = 16,
    parameter int IRQ_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic [2:0]       op_i,
    input  logic [PC_W-1:0]  target_i,
    input  logic             cond_sel_i,
    input  logic             cond_neg_i,
    input  logic             carry_i,
    input  logic             zero_i,
    input  logic [IRQ_W-1:0] irq_req_i,
    input  logic             csr_we_i,
    input  logic [1:0]       csr_sel_i,
    input  logic [IRQ_W-1:0] csr_wdata_i,
    output logic [PC_W-1:0]  pc_o,
    output logic             irq_entry_o,
    output logic             restore_o,
    output logic             carry_sh_o,
    output logic             zero_sh_o,
    output logic [IRQ_W-1:0] csr_rdata_o,
    output logic             stack_err_o
);

    localparam logic [PC_W-1:0] RESET_PC  = PC_W'(1);
    localparam logic [PC_W-1:0] VECTOR_PC = '0;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            err;
        logic            entry;
        logic            restore;
        logic            c_sh;
        logic            z_sh;
    } seq_t;

    seq_t            st_d, st_q;
    flow_dec_t       dec;
    logic            fire;
    logic            take;
    logic            push_req;
    logic            pop_req;
    logic [PC_W-1:0] push_data;
    logic [PC_W-1:0] stk_top;
    logic            stk_full;
    logic            stk_empty;
    logic            leave;
    logic [PC_W-1:0] pc_inc;

    flow_op_decode u_dec (
        .op_i       (flow_op_e'(op_i)),
        .cond_sel_i (cond_sel_i),
        .cond_neg_i (cond_neg_i),
        .carry_i    (carry_i),
        .zero_i     (zero_i),
        .dec_o      (dec)
    );

    flow_ret_stack #(
        .DEPTH (DEPTH),
        .W     (PC_W)
    ) u_stack (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (push_req),
        .pop_i       (pop_req),
        .push_data_i (push_data),
        .top_o       (stk_top),
        .full_o      (stk_full),
        .empty_o     (stk_empty)
    );

    flow_irq_ctrl #(
        .IRQ_W (IRQ_W)
    ) u_irq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .irq_req_i   (irq_req_i),
        .csr_we_i    (csr_we_i),
        .csr_sel_i   (csr_sel_e'(csr_sel_i)),
        .csr_wdata_i (csr_wdata_i),
        .enter_i     (take),
        .leave_i     (leave),
        .fire_o      (fire),
        .csr_rdata_o (csr_rdata_o)
    );

    always_comb begin
        st_d         = st_q;
        st_d.entry   = 1'b0;
        st_d.restore = 1'b0;
        take         = step_i && fire;
        leave        = 1'b0;
        push_req     = 1'b0;
        pop_req      = 1'b0;
        push_data    = '0;
        pc_inc       = st_q.pc + PC_W'(1);

        if (take) begin
            // interrupt entry replaces the request of this step
            push_req    = 1'b1;
            push_data   = st_q.pc;
            st_d.pc     = VECTOR_PC;
            st_d.c_sh   = carry_i;
            st_d.z_sh   = zero_i;
            st_d.entry  = 1'b1;
        end else if (step_i) begin
            st_d.pc = pc_inc;
            if (dec.jump) begin
                st_d.pc = target_i;
            end
            if (dec.call) begin
                push_req  = 1'b1;
                push_data = pc_inc;
                if (!stk_full) begin
                    st_d.pc = target_i;
                end
            end
            if (dec.ret || dec.iret) begin
                pop_req = 1'b1;
                if (!stk_empty) begin
                    st_d.pc = stk_top;
                end
            end
            if (dec.iret) begin
                leave        = 1'b1;
                st_d.restore = 1'b1;
            end
        end

        st_d.err = st_q.err || (push_req && stk_full) || (pop_req && stk_empty);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q    <= '0;
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o        = st_q.pc;
    assign irq_entry_o = st_q.entry;
    assign restore_o   = st_q.restore;
    assign carry_sh_o  = st_q.c_sh;
    assign zero_sh_o   = st_q.z_sh;
    assign stack_err_o = st_q.err;

endmodule

// File: rtl/flow_sequencer_chk.sv
module flow_sequencer_chk #(
    parameter int PC_W  = 12,
    parameter int IRQ_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             step_i,
    input logic             csr_we_i,
    input logic [1:0]       csr_sel_i,
    input logic [IRQ_W-1:0] csr_wdata_i,
    input logic [IRQ_W-1:0] csr_rdata_o,
    input logic [PC_W-1:0]  pc_o,
    input logic             irq_entry_o,
    input logic             stack_err_o
);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable(pc_o));

    // R10
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stack_err_o |=> stack_err_o);

    // R6
    entry_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_entry_o |-> pc_o == '0);

    // R6
    entry_needs_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_entry_o |-> $past(step_i));

    // R8
    mask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_we_i && csr_sel_i == 2'd1) |=>
            (csr_sel_i != 2'd1 || csr_rdata_o == $past(csr_wdata_i)));

endmodule

bind flow_sequencer flow_sequencer_chk #(
    .PC_W  (PC_W),
    .IRQ_W (IRQ_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step_i),
    .csr_we_i    (csr_we_i),
    .csr_sel_i   (csr_sel_i),
    .csr_wdata_i (csr_wdata_i),
    .csr_rdata_o (csr_rdata_o),
    .pc_o        (pc_o),
    .irq_entry_o (irq_entry_o),
    .stack_err_o (stack_err_o)
);

// File: tb/flow_sequencer_bench.sv
module flow_sequencer_bench;

    localparam int PC_W  = 12;
    localparam int DEPTH = 16;
    localparam int IRQ_W = 8;

    logic             clk = 1'b0;
    logic             rst_ni = 1'b0;
    logic             step_i = 1'b0;
    logic [2:0]       op_i = '0;
    logic [PC_W-1:0]  target_i = '0;
    logic             cond_sel_i = 1'b0;
    logic             cond_neg_i = 1'b0;
    logic             carry_i = 1'b0;
    logic             zero_i = 1'b0;
    logic [IRQ_W-1:0] irq_req_i = '0;
    logic             csr_we_i = 1'b0;
    logic [1:0]       csr_sel_i = '0;
    logic [IRQ_W-1:0] csr_wdata_i = '0;
    logic [PC_W-1:0]  pc_o;
    logic             irq_entry_o;
    logic             restore_o;
    logic             carry_sh_o;
    logic             zero_sh_o;
    logic [IRQ_W-1:0] csr_rdata_o;
    logic             stack_err_o;

    flow_sequencer #(.PC_W(PC_W), .DEPTH(DEPTH), .IRQ_W(IRQ_W)) u_flow_sequencer (
        .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .op_i(op_i),
        .target_i(target_i), .cond_sel_i(cond_sel_i), .cond_neg_i(cond_neg_i),
        .carry_i(carry_i), .zero_i(zero_i), .irq_req_i(irq_req_i),
        .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i),
        .pc_o(pc_o), .irq_entry_o(irq_entry_o), .restore_o(restore_o),
        .carry_sh_o(carry_sh_o), .zero_sh_o(zero_sh_o),
        .csr_rdata_o(csr_rdata_o), .stack_err_o(stack_err_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [PC_W-1:0] pc;
        logic            err;
        logic            entry;
        logic            restore;
        string           tag;
    } exp_t;

    exp_t            sb_q[$];
    int              checks = 0;
    int              fails  = 0;
    bit              finished = 1'b0;

    // reference model state
    logic [PC_W-1:0]  m_pc;
    logic [PC_W-1:0]  m_stk[$];
    logic             m_err, m_ie;
    logic [IRQ_W-1:0] m_ip, m_im;

    task automatic model_reset();
        m_pc = PC_W'(1); m_stk.delete(); m_err = 0; m_ie = 0; m_ip = '0; m_im = '0;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle of stimulus; expected outputs go to the scoreboard
    task automatic cyc(input bit st, input logic [2:0] op, input logic [PC_W-1:0] tgt,
                       input bit cs, input bit cn, input bit c, input bit z,
                       input logic [IRQ_W-1:0] irq, input bit we, input logic [1:0] sel,
                       input logic [IRQ_W-1:0] wd, input string tag);
        exp_t e;
        bit take, cond, jmp, call, ret, iret;
        logic [PC_W-1:0] inc;
        @(negedge clk);
        step_i = st; op_i = op; target_i = tgt; cond_sel_i = cs; cond_neg_i = cn;
        carry_i = c; zero_i = z; irq_req_i = irq; csr_we_i = we; csr_sel_i = sel;
        csr_wdata_i = wd;
        take = st && m_ie && |(m_ip & m_im);
        cond = (cs ? c : z) ^ cn;
        jmp  = (op == 3'd1) || (op == 3'd2 && cond);
        call = (op == 3'd3) || (op == 3'd4 && cond);
        ret  = (op == 3'd5);
        iret = (op == 3'd6);
        inc  = m_pc + PC_W'(1);
        e.entry = 0; e.restore = 0;
        if (we && sel == 2'd2) m_ie = |wd;
        if (take) begin
            if (m_stk.size() < DEPTH) m_stk.push_back(m_pc); else m_err = 1;
            m_pc = '0; m_ie = 0; e.entry = 1;
        end else if (st) begin
            m_pc = inc;
            if (jmp) m_pc = tgt;
            if (call) begin
                if (m_stk.size() < DEPTH) begin m_stk.push_back(inc); m_pc = tgt; end
                else m_err = 1;
            end
            if (ret || iret) begin
                if (m_stk.size() > 0) m_pc = m_stk.pop_back(); else m_err = 1;
            end
            if (iret) begin m_ie = 1; e.restore = 1; end
        end
        m_ip = ((we && sel == 2'd0) ? wd : m_ip) | irq;
        if (we && sel == 2'd1) m_im = wd;
        e.pc = m_pc; e.err = m_err; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic step_op(input logic [2:0] op, input logic [PC_W-1:0] tgt, input string tag);
        cyc(1, op, tgt, 0, 0, 0, 0, '0, 0, 2'd3, '0, tag);
    endtask

    task automatic csr_write(input logic [1:0] sel, input logic [IRQ_W-1:0] wd, input string tag);
        cyc(0, 3'd0, '0, 0, 0, 0, 0, '0, 1, sel, wd, tag);
    endtask

    task automatic csr_read(input logic [1:0] sel, input logic [IRQ_W-1:0] exp, input string tag);
        @(negedge clk);
        step_i = 0; csr_we_i = 0; irq_req_i = '0; csr_sel_i = sel;
        #1 check(csr_rdata_o === exp, tag, int'(csr_rdata_o), int'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ni = 0; step_i = 0; csr_we_i = 0; irq_req_i = '0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_ni = 1;
    endtask

    // monitor: compare after each rising edge, away from it
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (pc_o !== e.pc || stack_err_o !== e.err ||
                    irq_entry_o !== e.entry || restore_o !== e.restore) begin
                    fails++;
                    $display("FAIL %s: pc=%0d err=%0b entry=%0b restore=%0b expected pc=%0d err=%0b entry=%0b restore=%0b",
                             e.tag, pc_o, stack_err_o, irq_entry_o, restore_o,
                             e.pc, e.err, e.entry, e.restore);
                end
            end
        end
    end

    initial begin
        #(100000 * 10);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        #1 check(pc_o === 12'd1, "R1 pc", int'(pc_o), 1);
        check(stack_err_o === 1'b0 && irq_entry_o === 1'b0 && restore_o === 1'b0,
              "R1 flags", int'(stack_err_o), 0);
        csr_read(2'd0, 8'h00, "R1 pending");
        csr_read(2'd1, 8'h00, "R1 mask");
        csr_read(2'd2, 8'h00, "R1 enable");

        // R2 advance and hold
        cyc(0, 3'd0, 12'd77, 0, 0, 0, 0, '0, 0, 2'd3, '0, "R2 hold");
        step_op(3'd0, '0, "R2 advance");
        step_op(3'd7, 12'd99, "R2 reserved advance");
        // R3 jumps
        step_op(3'd1, 12'd20, "R3 jump");
        cyc(1, 3'd2, 12'd40, 0, 0, 0, 1, '0, 0, 2'd3, '0, "R3 jump if zero taken");
        cyc(1, 3'd2, 12'd90, 0, 0, 0, 0, '0, 0, 2'd3, '0, "R3 jump if zero not taken");
        cyc(1, 3'd2, 12'd60, 1, 1, 0, 0, '0, 0, 2'd3, '0, "R3 jump if not carry");
        // R4 / R5 calls
        step_op(3'd3, 12'd100, "R4 call");
        cyc(1, 3'd4, 12'd200, 1, 1, 0, 1, '0, 0, 2'd3, '0, "R5 call if not carry taken");
        cyc(1, 3'd4, 12'd300, 1, 0, 0, 1, '0, 0, 2'd3, '0, "R5 call if carry falls through");
        cyc(1, 3'd4, 12'd310, 0, 1, 1, 1, '0, 0, 2'd3, '0, "R5 call if not zero falls through");
        step_op(3'd5, '0, "R4 return inner");
        step_op(3'd5, '0, "R4 return outer");
        // R11 underflow
        step_op(3'd5, '0, "R11 return on empty");
        step_op(3'd0, '0, "R11 error held");

        do_reset();
        #1 check(stack_err_o === 1'b0, "R1 error cleared by reset", int'(stack_err_o), 0);
        // R8 control registers
        csr_write(2'd1, 8'h01, "R8 write mask");
        csr_write(2'd2, 8'h80, "R8 write enable");
        csr_read(2'd1, 8'h01, "R8 read mask");
        csr_read(2'd2, 8'h01, "R8 enable nonzero gives 1");
        csr_read(2'd3, 8'h00, "R8 select 3 reads 0");
        // R9 pending from request lines, masked bit does not fire
        cyc(1, 3'd0, '0, 0, 0, 0, 0, 8'h02, 0, 2'd3, '0, "R9 request captured");
        csr_read(2'd0, 8'h02, "R9 pending read");
        step_op(3'd0, '0, "R9 masked bit no entry");
        cyc(1, 3'd0, '0, 0, 0, 0, 0, 8'h01, 0, 2'd3, '0, "R9 request one cycle late");
        // R6 entry: call request discarded, flags shadowed
        cyc(1, 3'd3, 12'd500, 0, 0, 1, 0, '0, 0, 2'd3, '0, "R6 interrupt entry");
        csr_read(2'd2, 8'h00, "R6 enable cleared");
        #1 check(carry_sh_o === 1'b1 && zero_sh_o === 1'b0, "R6 shadow flags",
                 int'({carry_sh_o, zero_sh_o}), 2);
        // handler clears pending while a request holds one bit
        cyc(1, 3'd0, '0, 0, 0, 0, 0, 8'h04, 1, 2'd0, 8'h10, "R9 write during request");
        csr_read(2'd0, 8'h14, "R9 write ORed with request");
        csr_write(2'd0, 8'h00, "R9 clear pending");
        csr_read(2'd0, 8'h00, "R9 pending cleared");
        // R7 return from interrupt
        cyc(1, 3'd6, '0, 0, 0, 0, 1, '0, 0, 2'd3, '0, "R7 interrupt return");
        #1 check(carry_sh_o === 1'b1 && zero_sh_o === 1'b0, "R7 shadow presented",
                 int'({carry_sh_o, zero_sh_o}), 2);
        csr_read(2'd2, 8'h01, "R7 enable set");
        step_op(3'd0, '0, "R7 resume");

        // R10 overflow
        for (int i = 0; i < DEPTH; i++) begin
            step_op(3'd3, m_pc + PC_W'(5), "R10 fill");
        end
        step_op(3'd3, 12'd4000, "R10 call on full stack");
        for (int i = 0; i < DEPTH; i++) begin
            step_op(3'd5, '0, "R10 unwind intact");
        end
        step_op(3'd0, '0, "R10 error sticky");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule